// File: doc/BRIEF.md
# Programmable Interval Timer

A peripheral holding three independent 16-bit down-counters behind an 8-bit processor bus. Every channel has its own count clock input, a gate input and a waveform output. Software picks a channel and writes a command byte that sets how the count is accessed, which counting mode runs and whether the count is binary or four BCD decades. It then loads the initial count one byte at a time. The running count can be frozen by a latch command and read back over the same bus.

The bus is sampled on the system clock. A write or read takes effect once per strobe, on the first system clock edge that sees the strobe low while chip select is low. Channel clocks and gates are sampled on the system clock too. A channel counts on each sampled rising edge of its channel clock. A count written to a channel takes effect two system clocks after the write edge.

Top module: `prog_interval_timer`

## Requirements
- R1: Address 0, 1 and 2 reach the count register of channel 0, 1 and 2. Address 3 is the write-only command register. Command bits [7:6] name the target channel, and the value 3 there makes the command have no effect.
- R2: Reads and writes happen only while `cs_n` is low. Channels keep counting on their clock edges whatever the state of `cs_n`, and a count changes only on a channel clock edge, a count load or a gate trigger.
- R3: Command bits [3:1] select the mode. 000 is mode 0, 001 mode 1, x10 mode 2, x11 mode 3, 100 mode 4 and 101 mode 5, so bit 3 is ignored for modes 2 and 3. Bit 0 selects BCD counting.
- R4: Command bits [5:4] give the access order. 01 moves the low byte only and clears the high byte on a write. 10 moves the high byte only and clears the low byte on a write. 11 moves the low byte and then the high byte, for writes and for reads alike.
- R5: Access code 00 latches the current count. Reads return the frozen value until it has been read out completely in the programmed order. A second latch command before that point has no effect.
- R6: Mode 0: the output goes low on the command write and again on a count load. It goes high after N channel clock edges for a count of N, and stays high while the count keeps running down.
- R7: Mode 2: the output is high and goes low for one channel clock period every N edges, when the count reaches 1. The count then reloads N.
- R8: Mode 3: square wave with a period of N edges. The high half lasts (N+1)/2 edges and the low half N/2 edges, so for odd N the high half is one edge longer.
- R9: BCD counting steps through four decimal digits. A count of 0 stands for the maximum: 65536 edges in binary, 10000 in BCD. Binary counts wrap from 0 to 0xFFFF.
- R10: In modes 0, 2, 3 and 4 a low gate stops counting. In modes 2 and 3 a low gate also forces the output high, and a rising gate reloads the count.
- R11: Modes 1 and 5 start on a rising gate after a count has been loaded. Mode 1 drives the output low until N edges have passed. Mode 5 keeps the output high and pulses it low for one period after N edges.
- R12: Mode 4 starts when the count is loaded. The output stays high and pulses low for one channel clock period after N edges.
- R13: After reset every channel is idle in mode 0, the outputs are low, the count reads 0, the access order is low byte then high byte, and `rdata` is 0.
- R14: `rdata` is registered on the read strobe's first edge and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, registered |
| ch_clk | input | 3 | Count clock per channel |
| ch_gate | input | 3 | Gate per channel |
| ch_out | output | 3 | Waveform output per channel |

## Verification
The bench builds the block with its default parameters, three channels on a two-bit address. Small counts then bring every output period within a few dozen channel clock edges. This allows full sweeps of mode 0 over counts 1 to 6, mode 2 over 2 to 10 and mode 3 over 2 to 9, each compared edge by edge against arithmetic waveforms, with bit 3 of the mode field alternating between odd and even counts. The maximum count is reached with a full 10000-edge BCD run in mode 2, and with a single decrement of a binary zero.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    MD_INT_TC    = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } pit_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } pit_acc_e;

  // bit 2 of the field is ignored whenever bit 1 is set
  function automatic pit_mode_e mode_of(input logic [2:0] m);
    return m[1] ? pit_mode_e'({1'b0, m[1:0]}) : pit_mode_e'(m);
  endfunction

  // subtract one or two, binary or per decimal digit with borrow
  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v,
                                               input logic bcd,
                                               input logic by_two);
    logic [CNT_W-1:0] r;
    logic [4:0] sub;
    logic [4:0] d;
    r = v;
    if (!bcd) begin
      r = v - (by_two ? CNT_W'(2) : CNT_W'(1));
    end else begin
      sub = by_two ? 5'd2 : 5'd1;
      for (int i = 0; i < DIGITS; i++) begin
        d = {1'b0, v[4*i +: 4]};
        if (d >= sub) begin
          r[4*i +: 4] = 4'(d - sub);
          sub = 5'd0;
        end else begin
          r[4*i +: 4] = 4'(d + 5'd10 - sub);
          sub = 5'd1;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_bus.sv
module pit_bus #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] sc,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] rd_ev
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  logic wr_q, rd_q, wr_n_nx, rd_n_nx;
  logic wr_ev, rd_any;

  always_comb begin
    wr_n_nx = wr_n;
    rd_n_nx = rd_n;
    wr_ev   = !cs_n && !wr_n && wr_q;
    rd_any  = !cs_n && !rd_n && rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n_nx;
      rd_q <= rd_n_nx;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ctrl_we[i] = wr_ev && (addr == CTRL_ADDR) && (sc == ADDR_W'(i));
    assign data_we[i] = wr_ev && (addr == ADDR_W'(i));
    assign rd_ev[i]   = rd_any && (addr == ADDR_W'(i));
  end

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, data_we, rd_ev}));
endmodule

// File: rtl/pit_access.sv
module pit_access
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              data_we,
  input  logic              rd_ev,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [CNT_W-1:0]  live_cnt,
  output pit_mode_e         mode,
  output logic              bcd,
  output logic              ctrl_new,
  output logic [CNT_W-1:0]  cr,
  output logic              cr_ld,
  output logic [BYTE_W-1:0] rd_byte
);
  pit_acc_e          rw_q, rw_n;
  pit_mode_e         mode_q, mode_n;
  logic              bcd_q, bcd_n;
  logic              wptr_q, wptr_n, rptr_q, rptr_n;
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic [CNT_W-1:0]  cr_q, cr_n, latch_q, latch_n, src;
  logic              latched_q, latched_n;
  logic              cr_ld_q, cr_ld_n, ctrl_new_q, ctrl_new_n;

  always_comb begin
    rw_n = rw_q; mode_n = mode_q; bcd_n = bcd_q;
    wptr_n = wptr_q; rptr_n = rptr_q; lo_n = lo_q; cr_n = cr_q;
    latch_n = latch_q; latched_n = latched_q;
    cr_ld_n = 1'b0; ctrl_new_n = 1'b0;
    if (ctrl_we) begin
      if (wbyte[5:4] == ACC_LATCH) begin
        if (!latched_q) begin
          latched_n = 1'b1;
          latch_n   = live_cnt;
        end
      end else begin
        rw_n       = pit_acc_e'(wbyte[5:4]);
        mode_n     = mode_of(wbyte[3:1]);
        bcd_n      = wbyte[0];
        wptr_n     = 1'b0;
        rptr_n     = 1'b0;
        latched_n  = 1'b0;
        ctrl_new_n = 1'b1;
      end
    end else if (data_we) begin
      case (rw_q)
        ACC_LO: begin
          cr_n = {{BYTE_W{1'b0}}, wbyte};
          cr_ld_n = 1'b1;
        end
        ACC_HI: begin
          cr_n = {wbyte, {BYTE_W{1'b0}}};
          cr_ld_n = 1'b1;
        end
        ACC_BOTH: begin
          if (!wptr_q) begin
            lo_n   = wbyte;
            wptr_n = 1'b1;
          end else begin
            cr_n    = {wbyte, lo_q};
            cr_ld_n = 1'b1;
            wptr_n  = 1'b0;
          end
        end
        default: ;
      endcase
    end else if (rd_ev) begin
      if (rw_q == ACC_BOTH) begin
        rptr_n = !rptr_q;
        if (rptr_q) latched_n = 1'b0;
      end else begin
        latched_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= ACC_BOTH; mode_q <= MD_INT_TC; bcd_q <= 1'b0;
      wptr_q <= 1'b0; rptr_q <= 1'b0; lo_q <= '0; cr_q <= '0;
      latch_q <= '0; latched_q <= 1'b0; cr_ld_q <= 1'b0; ctrl_new_q <= 1'b0;
    end else begin
      rw_q <= rw_n; mode_q <= mode_n; bcd_q <= bcd_n;
      wptr_q <= wptr_n; rptr_q <= rptr_n; lo_q <= lo_n; cr_q <= cr_n;
      latch_q <= latch_n; latched_q <= latched_n;
      cr_ld_q <= cr_ld_n; ctrl_new_q <= ctrl_new_n;
    end
  end

  always_comb begin
    src = latched_q ? latch_q : live_cnt;
    case (rw_q)
      ACC_HI:  rd_byte = src[CNT_W-1 -: BYTE_W];
      ACC_LO:  rd_byte = src[BYTE_W-1:0];
      default: rd_byte = rptr_q ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
    endcase
  end

  assign mode     = mode_q;
  assign bcd      = bcd_q;
  assign cr       = cr_q;
  assign cr_ld    = cr_ld_q;
  assign ctrl_new = ctrl_new_q;

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !rd_ev && !(ctrl_we && wbyte[5:4] != 2'b00))
      |=> (latched_q && $stable(latch_q)));

  assert_wptr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_q != ACC_BOTH) |-> !wptr_q);
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_clk,
  input  logic             gate,
  input  pit_mode_e        mode,
  input  logic             bcd,
  input  logic             ctrl_new,
  input  logic [CNT_W-1:0] cr,
  input  logic             cr_ld,
  output logic [CNT_W-1:0] cnt,
  output logic             out
);
  logic [CNT_W-1:0] cnt_q, cnt_n, dec1, dec2;
  logic out_q, out_n, run_q, run_n, armed_q, armed_n, loaded_q, loaded_n;
  logic clk_q, gate_q, tick, gate_rise, sq_flip, trig_mode, per_mode;

  always_comb begin
    tick      = ch_clk && !clk_q;
    gate_rise = gate && !gate_q;
    trig_mode = (mode == MD_ONESHOT) || (mode == MD_HW_STROBE);
    per_mode  = (mode == MD_RATE) || (mode == MD_SQUARE);
    dec1      = cnt_dec(cnt_q, bcd, 1'b0);
    dec2      = cnt_dec(cnt_q, bcd, 1'b1);
    sq_flip   = out_q ? ((cnt_q == CNT_W'(1)) || (cnt_q == CNT_W'(2)))
                      : (cr[0] ? (cnt_q == CNT_W'(3)) : (cnt_q == CNT_W'(2)));
  end

  always_comb begin
    cnt_n = cnt_q; out_n = out_q; run_n = run_q;
    armed_n = armed_q; loaded_n = loaded_q;
    if (ctrl_new) begin
      run_n = 1'b0; armed_n = 1'b0; loaded_n = 1'b0;
      out_n = (mode != MD_INT_TC);
    end else if (cr_ld) begin
      loaded_n = 1'b1;
      case (mode)
        MD_INT_TC: begin
          cnt_n = cr; run_n = 1'b1; out_n = 1'b0;
        end
        MD_SW_STROBE: begin
          cnt_n = cr; run_n = 1'b1; armed_n = 1'b1; out_n = 1'b1;
        end
        MD_RATE, MD_SQUARE: begin
          if (!run_q) begin
            cnt_n = cr; run_n = 1'b1; out_n = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (gate_rise && trig_mode && loaded_q) begin
      cnt_n = cr; run_n = 1'b1; armed_n = 1'b1;
      out_n = (mode != MD_ONESHOT);
    end else if (gate_rise && per_mode && run_q) begin
      cnt_n = cr; out_n = 1'b1;
    end else if (per_mode && !gate) begin
      out_n = 1'b1;
    end else if (tick && run_q) begin
      case (mode)
        MD_INT_TC: begin
          if (gate) begin
            cnt_n = dec1;
            if (dec1 == '0) out_n = 1'b1;
          end
        end
        MD_ONESHOT: begin
          cnt_n = dec1;
          if (armed_q && dec1 == '0) begin
            out_n = 1'b1; armed_n = 1'b0;
          end
        end
        MD_RATE: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_n = cr; out_n = 1'b1;
          end else begin
            cnt_n = dec1; out_n = (dec1 != CNT_W'(1));
          end
        end
        MD_SQUARE: begin
          if (sq_flip) begin
            cnt_n = cr; out_n = !out_q;
          end else begin
            cnt_n = dec2;
          end
        end
        MD_SW_STROBE, MD_HW_STROBE: begin
          if (gate || mode == MD_HW_STROBE) begin
            cnt_n = dec1;
            if (armed_q && dec1 == '0) begin
              out_n = 1'b0; armed_n = 1'b0;
            end else begin
              out_n = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; out_q <= 1'b0; run_q <= 1'b0; armed_q <= 1'b0;
      loaded_q <= 1'b0; clk_q <= 1'b0; gate_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n; out_q <= out_n; run_q <= run_n; armed_q <= armed_n;
      loaded_q <= loaded_n; clk_q <= ch_clk; gate_q <= gate;
    end
  end

  assign cnt = cnt_q;
  assign out = out_q;

  assert_ctrl_m0_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_new && mode == MD_INT_TC) |=> !out_q);

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cr_ld && !gate_rise) |=> $stable(cnt_q));

  assert_rate_low_at_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RATE && $fell(out_q)) |-> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [NUM_CH-1:0] ch_clk,
  input  logic [NUM_CH-1:0] ch_gate,
  output logic [NUM_CH-1:0] ch_out
);
  logic [NUM_CH-1:0] ctrl_we, data_we, rd_ev;
  logic [BYTE_W-1:0] rd_byte [NUM_CH];
  logic [BYTE_W-1:0] rdata_q, rdata_n;

  pit_bus #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .sc(wdata[BYTE_W-1 -: ADDR_W]),
    .ctrl_we(ctrl_we), .data_we(data_we), .rd_ev(rd_ev)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pit_mode_e        mode;
    logic             bcd, ctrl_new, cr_ld;
    logic [CNT_W-1:0] cr, cnt;

    pit_access u_acc (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we[i]), .data_we(data_we[i]),
      .rd_ev(rd_ev[i]), .wbyte(wdata), .live_cnt(cnt), .mode(mode), .bcd(bcd),
      .ctrl_new(ctrl_new), .cr(cr), .cr_ld(cr_ld), .rd_byte(rd_byte[i])
    );

    pit_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .ch_clk(ch_clk[i]), .gate(ch_gate[i]),
      .mode(mode), .bcd(bcd), .ctrl_new(ctrl_new), .cr(cr), .cr_ld(cr_ld),
      .cnt(cnt), .out(ch_out[i])
    );
  end

  always_comb begin
    rdata_n = rdata_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ev[i]) rdata_n = rd_byte[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;

  assert_rdata_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rd_ev) |=> $stable(rdata_q));
endmodule

// File: tb/sim_prog_interval_timer.sv
module sim_prog_interval_timer;
  logic clk = 1'b0;
  logic rst_n, cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] ch_clk, ch_gate, ch_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prog_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .ch_clk(ch_clk), .ch_gate(ch_gate), .ch_out(ch_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic cs = 1'b0);
    @(negedge clk); cs_n = cs; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic rd16(input logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    bus_rd(a, lo);
    bus_rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic load(input logic [1:0] ch, input logic [7:0] ctrl, input int n);
    bus_wr(2'd3, ctrl);
    bus_wr(ch, n[7:0]);
    bus_wr(ch, n[15:8]);
  endtask

  task automatic tick(input int ch);
    @(negedge clk); ch_clk[ch] = 1'b1;
    @(negedge clk); ch_clk[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_gate(input int ch, input logic v);
    @(negedge clk); ch_gate[ch] = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, h;
    logic [7:0] b, b2;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; wdata = '0; ch_clk = '0; ch_gate = 3'b111;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk(ch_out == 3'b000, "R13 outputs after reset", ch_out, 0);
    chk(rdata == 8'h00, "R13 rdata after reset", rdata, 0);
    rd16(2'd0, v);
    chk(v == 0, "R13 count after reset", v, 0);

    // R6 mode 0 sweep on channel 0
    for (int n = 1; n <= 6; n++) begin
      bus_wr(2'd3, 8'h30);
      chk(ch_out[0] == 1'b0, "R6 low after command", ch_out[0], 0);
      bus_wr(2'd0, n[7:0]);
      bus_wr(2'd0, 8'h00);
      for (int k = 1; k <= n + 2; k++) begin
        tick(0);
        chk(ch_out[0] == (k >= n), "R6 terminal count", ch_out[0], (k >= n));
      end
      rd16(2'd0, v);
      chk(v == 16'hFFFE, "R9 binary wrap", v, 16'hFFFE);
    end

    // R7 mode 2 sweep on channel 1, R3 mode bit 3 ignored on odd counts
    for (int n = 2; n <= 10; n++) begin
      load(2'd1, (n % 2) ? 8'h7C : 8'h74, n);
      chk(ch_out[1] == 1'b1, "R7 high after load", ch_out[1], 1);
      for (int k = 1; k <= 2 * n; k++) begin
        tick(1);
        chk(ch_out[1] == ((k % n) != n - 1), "R7 R3 rate output", ch_out[1], ((k % n) != n - 1));
      end
    end

    // R8 mode 3 sweep on channel 2
    for (int n = 2; n <= 9; n++) begin
      load(2'd2, (n % 2) ? 8'hBE : 8'hB6, n);
      h = (n + 1) / 2;
      chk(ch_out[2] == 1'b1, "R8 high after load", ch_out[2], 1);
      for (int k = 1; k <= 2 * n; k++) begin
        tick(2);
        chk(ch_out[2] == ((k % n) < h), "R8 square output", ch_out[2], ((k % n) < h));
      end
    end

    // R9 BCD decrement across a decade
    load(2'd0, 8'h31, 16'h0010);
    tick(0);
    rd16(2'd0, v);
    chk(v == 16'h0009, "R9 BCD borrow", v, 16'h0009);

    // R9 BCD zero is 10000 edges in mode 2
    load(2'd1, 8'h75, 0);
    for (int k = 1; k <= 9998; k++) tick(1);
    chk(ch_out[1] == 1'b1, "R9 BCD max before end", ch_out[1], 1);
    tick(1);
    chk(ch_out[1] == 1'b0, "R9 BCD max pulse at 9999", ch_out[1], 0);
    tick(1);
    chk(ch_out[1] == 1'b1, "R9 BCD max reload at 10000", ch_out[1], 1);

    // R9 binary zero wraps to 0xFFFF
    load(2'd0, 8'h30, 0);
    tick(0);
    rd16(2'd0, v);
    chk(v == 16'hFFFF, "R9 binary max", v, 16'hFFFF);

    // R4 low byte only and high byte only
    bus_wr(2'd3, 8'h10);
    bus_wr(2'd0, 8'h07);
    tick(0); tick(0);
    bus_rd(2'd0, b);
    chk(b == 8'h05, "R4 low byte only", b, 5);
    bus_wr(2'd3, 8'h20);
    bus_wr(2'd0, 8'h01);
    bus_rd(2'd0, b);
    chk(b == 8'h01, "R4 high byte only load", b, 1);
    tick(0);
    bus_rd(2'd0, b);
    chk(b == 8'h00, "R4 high byte only after edge", b, 0);

    // R2 writes ignored with chip select high, counting continues
    load(2'd0, 8'h30, 50);
    tick(0); tick(0);
    bus_wr(2'd3, 8'h10, 1'b1);
    bus_wr(2'd0, 8'h05, 1'b1);
    bus_wr(2'd0, 8'h00, 1'b1);
    tick(0);
    rd16(2'd0, v);
    chk(v == 47, "R2 deselected writes ignored", v, 47);

    // R1 select value 3 has no effect
    bus_wr(2'd3, 8'hD0);
    chk(ch_out[1] == 1'b1, "R1 illegal select leaves channel 1", ch_out[1], 1);
    rd16(2'd0, v);
    chk(v == 47, "R1 illegal select leaves channel 0", v, 47);

    // R5 latch on channel 1
    load(2'd1, 8'h74, 200);
    for (int k = 0; k < 5; k++) tick(1);
    bus_wr(2'd3, 8'h40);
    for (int k = 0; k < 3; k++) tick(1);
    bus_wr(2'd3, 8'h40);
    tick(1); tick(1);
    rd16(2'd1, v);
    chk(v == 195, "R5 latched value", v, 195);
    rd16(2'd1, v);
    chk(v == 190, "R5 live after full read", v, 190);

    // R14 rdata holds between reads
    b = rdata;
    tick(1);
    repeat (3) @(negedge clk);
    chk(rdata == b, "R14 rdata held", rdata, b);

    // R10 gate in mode 0
    load(2'd0, 8'h30, 10);
    set_gate(0, 1'b0);
    tick(0); tick(0); tick(0);
    rd16(2'd0, v);
    chk(v == 10, "R10 mode 0 gate low holds", v, 10);
    set_gate(0, 1'b1);
    tick(0); tick(0); tick(0);
    rd16(2'd0, v);
    chk(v == 7, "R10 mode 0 gate high counts", v, 7);

    // R10 gate in mode 2 (channel 1 holds 189)
    set_gate(1, 1'b0);
    tick(1); tick(1);
    rd16(2'd1, v);
    chk(v == 189, "R10 mode 2 gate low holds", v, 189);
    chk(ch_out[1] == 1'b1, "R10 mode 2 gate low output high", ch_out[1], 1);
    set_gate(1, 1'b1);
    rd16(2'd1, v);
    chk(v == 200, "R10 mode 2 gate rise reloads", v, 200);

    // R10 gate low forces mode 3 high
    load(2'd2, 8'hB6, 4);
    tick(2); tick(2);
    chk(ch_out[2] == 1'b0, "R8 low half", ch_out[2], 0);
    set_gate(2, 1'b0);
    chk(ch_out[2] == 1'b1, "R10 mode 3 gate low forces high", ch_out[2], 1);
    set_gate(2, 1'b1);

    // R11 mode 1 on channel 0
    load(2'd0, 8'h32, 3);
    set_gate(0, 1'b0);
    tick(0); tick(0);
    chk(ch_out[0] == 1'b1, "R11 mode 1 idle until trigger", ch_out[0], 1);
    set_gate(0, 1'b1);
    chk(ch_out[0] == 1'b0, "R11 mode 1 low on trigger", ch_out[0], 0);
    tick(0); tick(0);
    chk(ch_out[0] == 1'b0, "R11 mode 1 still low", ch_out[0], 0);
    tick(0);
    chk(ch_out[0] == 1'b1, "R11 mode 1 high after N", ch_out[0], 1);

    // R11 mode 5 on channel 1
    load(2'd1, 8'h7A, 2);
    set_gate(1, 1'b0);
    set_gate(1, 1'b1);
    tick(1);
    chk(ch_out[1] == 1'b1, "R11 mode 5 high before N", ch_out[1], 1);
    tick(1);
    chk(ch_out[1] == 1'b0, "R11 mode 5 strobe", ch_out[1], 0);
    tick(1);
    chk(ch_out[1] == 1'b1, "R11 mode 5 strobe ends", ch_out[1], 1);

    // R12 mode 4 on channel 2
    load(2'd2, 8'hB8, 3);
    for (int k = 1; k <= 6; k++) begin
      tick(2);
      chk(ch_out[2] == (k != 3), "R12 software strobe", ch_out[2], (k != 3));
    end

    // R14 second read returns the new byte
    bus_rd(2'd2, b2);
    chk(rdata == b2, "R14 rdata after read", rdata, b2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule